// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the software-visible register file of a platform-level interrupt controller that serves `SRC_COUNT` interrupt sources and `TGT_COUNT` targets. It sits on a simple word-addressed bus with one request per cycle. It stores one priority per source, shared by all targets. Each target has a packed set of enable words and a threshold. Each hart has a software-interrupt bit. The stored configuration leaves the block as flat vectors, which feed an external arbiter and external gateways.

The block also presents a read-only view of the pending bits, which arrive from the gateways. It provides one claim/complete register per target. A read of that register returns the winning source ID that the external arbiter supplies for the target, and it emits a one-cycle claim pulse. A write emits a one-cycle completion pulse that carries the written ID. The arbitration and the gateway logic live outside this block and connect through ports.

The address map is contiguous and is derived from the parameters. The priorities come first, then the pending words, the enable words, the thresholds, the claim/complete registers and the software-interrupt bits.

Top module: `irqc_regs`

## Requirements
- R1: After reset, every priority, enable bit, threshold and software-interrupt bit is zero. The claim and completion pulses are low. A read of any address returns zero.
- R2: Source i has a priority register at word PRIO_BASE+i. A write keeps only the low PRIO_W bits, where PRIO_W = clog2(PRIO_MAX+1). A read returns them zero-extended, and `cfg_prio[i*PRIO_W +: PRIO_W]` shows the stored value.
- R3: Let W = ceil(SRC_COUNT/32). The enable bit for source i of target t sits in word IE_BASE + W*t + (i>>5), at bit i%32, and appears on `cfg_enable[t*SRC_COUNT+i]`. Bit positions that map to no source read as zero.
- R4: Target t has a threshold at word THR_BASE+t. It holds the low PRIO_W bits and appears on `cfg_thresh[t*PRIO_W +: PRIO_W]`.
- R5: The pending view spans W words starting at PEND_BASE. Bit b of word w reads `src_pending[32*w+b]`, and bits beyond the last source read as zero. A write to the pending view changes nothing.
- R6: A read of word CC_BASE+t returns the ID on `tgt_win_id[t*ID_W +: ID_W]` as sampled at the request edge. If that ID is nonzero, the same cycle raises `claim_valid` with `claim_tgt`=t and `claim_id` equal to the returned ID. If the ID is zero, no claim is issued.
- R7: A write of value v to word CC_BASE+t raises `complete_valid` for one cycle with `complete_tgt`=t and `complete_id`=v, but only when 1 <= v < SRC_COUNT. Any other value produces no completion.
- R8: Hart h has a software-interrupt bit at word SWI_BASE+h, in bit 0. It drives `soft_irq[h]`, and a read returns it in bit 0.
- R9: A read of an address beyond the map returns zero. A write there changes no stored state. Every read produces `rsp_valid` exactly one cycle after the request edge, and a write produces none.
- R10: The map is laid out as follows, with N = SRC_COUNT and T = TGT_COUNT: PRIO_BASE = 0, PEND_BASE = N, IE_BASE = N+W, THR_BASE = IE_BASE + T*W, CC_BASE = THR_BASE + T, SWI_BASE = CC_BASE + T. The map ends at SWI_BASE + HART_COUNT. The claim and completion pulses never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | DATA_W | Read data |
| src_pending | input | SRC_COUNT | Pending bits from the gateways |
| tgt_win_id | input | TGT_COUNT*ID_W | Winning source ID per target, from the arbiter |
| cfg_prio | output | SRC_COUNT*PRIO_W | Priority per source |
| cfg_enable | output | TGT_COUNT*SRC_COUNT | Enable bit per target and source |
| cfg_thresh | output | TGT_COUNT*PRIO_W | Threshold per target |
| soft_irq | output | HART_COUNT | Software interrupt per hart |
| claim_valid | output | 1 | One-cycle claim pulse |
| claim_tgt | output | TGT_W | Claiming target |
| claim_id | output | ID_W | Claimed source ID |
| complete_valid | output | 1 | One-cycle completion pulse |
| complete_tgt | output | TGT_W | Completing target |
| complete_id | output | ID_W | Completed source ID |

## Verification
Every result of this block is due one clock edge after the edge that samples the request. This holds for a stored value showing on the configuration vectors, for read data together with `rsp_valid`, and for the claim and completion pulses. The bench drives each request on a falling edge and withdraws it on the next falling edge. It samples every output at that same falling edge, half a period after the edge that registered the result, so no check races the design. The idle cycle between requests lets the bench confirm that each pulse lasts only one cycle. The sweeps cover every mapped word, every completion ID up to 63, and every unmapped address.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Address-map region selected by the decoder
    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_IE,
        RG_THR,
        RG_CC,
        RG_SWI
    } irqc_region_e;

endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
    import irqc_pkg::*;
#(
    parameter int SRC_COUNT  = 40,
    parameter int TGT_COUNT  = 2,
    parameter int HART_COUNT = 2,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output irqc_region_e      region,
    output logic [ADDR_W-1:0] offset
);
    localparam int          WORDS     = (SRC_COUNT + DATA_W - 1) / DATA_W;
    localparam logic [31:0] PEND_BASE = 32'(SRC_COUNT);
    localparam logic [31:0] IE_BASE   = PEND_BASE + 32'(WORDS);
    localparam logic [31:0] THR_BASE  = IE_BASE + 32'(TGT_COUNT * WORDS);
    localparam logic [31:0] CC_BASE   = THR_BASE + 32'(TGT_COUNT);
    localparam logic [31:0] SWI_BASE  = CC_BASE + 32'(TGT_COUNT);
    localparam logic [31:0] MAP_END   = SWI_BASE + 32'(HART_COUNT);

    logic [31:0] a;

    always_comb begin
        a      = 32'(addr);
        region = RG_NONE;
        offset = '0;
        if (a < PEND_BASE) begin
            region = RG_PRIO;
            offset = ADDR_W'(a);
        end else if (a < IE_BASE) begin
            region = RG_PEND;
            offset = ADDR_W'(a - PEND_BASE);
        end else if (a < THR_BASE) begin
            region = RG_IE;
            offset = ADDR_W'(a - IE_BASE);
        end else if (a < CC_BASE) begin
            region = RG_THR;
            offset = ADDR_W'(a - THR_BASE);
        end else if (a < SWI_BASE) begin
            region = RG_CC;
            offset = ADDR_W'(a - CC_BASE);
        end else if (a < MAP_END) begin
            region = RG_SWI;
            offset = ADDR_W'(a - SWI_BASE);
        end
    end

    // R10: a selected claim/complete word always names an existing target
    always_comb begin
        assert_cc_offset_in_range_R10: assert (region != RG_CC || 32'(offset) < 32'(TGT_COUNT));
    end

endmodule

// File: rtl/irqc_cfg_store.sv
module irqc_cfg_store
    import irqc_pkg::*;
#(
    parameter int SRC_COUNT  = 40,
    parameter int TGT_COUNT  = 2,
    parameter int HART_COUNT = 2,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int PRIO_W     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  irqc_region_e                  region,
    input  logic [ADDR_W-1:0]             offset,
    input  logic [DATA_W-1:0]             wdata,
    output logic [SRC_COUNT*PRIO_W-1:0]   prio_q,
    output logic [TGT_COUNT*SRC_COUNT-1:0] ie_q,
    output logic [TGT_COUNT*PRIO_W-1:0]   thr_q,
    output logic [HART_COUNT-1:0]         swi_q,
    output logic [DATA_W-1:0]             cfg_rdata
);
    localparam int WORDS = (SRC_COUNT + DATA_W - 1) / DATA_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            ie_q   <= '0;
            thr_q  <= '0;
            swi_q  <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < SRC_COUNT; i++) begin
                if (region == RG_PRIO && offset == ADDR_W'(i))
                    prio_q[i*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
            end
            for (int t = 0; t < TGT_COUNT; t++) begin
                for (int i = 0; i < SRC_COUNT; i++) begin
                    if (region == RG_IE && offset == ADDR_W'(t * WORDS + i / DATA_W))
                        ie_q[t*SRC_COUNT + i] <= wdata[i % DATA_W];
                end
                if (region == RG_THR && offset == ADDR_W'(t))
                    thr_q[t*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
            end
            for (int h = 0; h < HART_COUNT; h++) begin
                if (region == RG_SWI && offset == ADDR_W'(h))
                    swi_q[h] <= wdata[0];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (region)
            RG_PRIO: begin
                for (int i = 0; i < SRC_COUNT; i++)
                    if (offset == ADDR_W'(i))
                        cfg_rdata = DATA_W'(prio_q[i*PRIO_W +: PRIO_W]);
            end
            RG_IE: begin
                for (int t = 0; t < TGT_COUNT; t++)
                    for (int w = 0; w < WORDS; w++)
                        if (offset == ADDR_W'(t * WORDS + w))
                            for (int b = 0; b < DATA_W; b++)
                                if (w * DATA_W + b < SRC_COUNT)
                                    cfg_rdata[b] = ie_q[t*SRC_COUNT + w*DATA_W + b];
            end
            RG_THR: begin
                for (int t = 0; t < TGT_COUNT; t++)
                    if (offset == ADDR_W'(t))
                        cfg_rdata = DATA_W'(thr_q[t*PRIO_W +: PRIO_W]);
            end
            RG_SWI: begin
                for (int h = 0; h < HART_COUNT; h++)
                    if (offset == ADDR_W'(h))
                        cfg_rdata = DATA_W'(swi_q[h]);
            end
            default: cfg_rdata = '0;
        endcase
    end

    // R1: the first cycle out of reset starts from a cleared configuration
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (prio_q == '0 && ie_q == '0 && thr_q == '0 && swi_q == '0));

    // R5: a write aimed at the pending view leaves every stored field alone
    assert_pend_write_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RG_PEND) |=> ($stable(prio_q) && $stable(ie_q) && $stable(thr_q) && $stable(swi_q)));

    // R9: an unmapped write leaves every stored field alone
    assert_unmapped_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RG_NONE) |=> ($stable(prio_q) && $stable(ie_q) && $stable(thr_q) && $stable(swi_q)));

endmodule

// File: rtl/irqc_cc_port.sv
module irqc_cc_port
    import irqc_pkg::*;
#(
    parameter int SRC_COUNT = 40,
    parameter int TGT_COUNT = 2,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int ID_W      = 6,
    parameter int TGT_W     = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic                      wr_en,
    input  irqc_region_e              region,
    input  logic [ADDR_W-1:0]         offset,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [TGT_COUNT*ID_W-1:0] win_id,
    output logic [DATA_W-1:0]         cc_rdata,
    output logic                      claim_valid,
    output logic [TGT_W-1:0]          claim_tgt,
    output logic [ID_W-1:0]           claim_id,
    output logic                      complete_valid,
    output logic [TGT_W-1:0]          complete_tgt,
    output logic [ID_W-1:0]           complete_id
);
    logic [ID_W-1:0] sel_id;
    logic            cc_hit;
    logic            do_claim;
    logic            do_complete;

    always_comb begin
        sel_id = '0;
        for (int t = 0; t < TGT_COUNT; t++)
            if (offset == ADDR_W'(t))
                sel_id = win_id[t*ID_W +: ID_W];
        cc_hit      = (region == RG_CC);
        cc_rdata    = DATA_W'(sel_id);
        do_claim    = rd_en && cc_hit && (sel_id != '0);
        do_complete = wr_en && cc_hit && (wdata != '0) && (wdata < DATA_W'(SRC_COUNT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            claim_valid    <= 1'b0;
            claim_tgt      <= '0;
            claim_id       <= '0;
            complete_valid <= 1'b0;
            complete_tgt   <= '0;
            complete_id    <= '0;
        end else begin
            claim_valid    <= do_claim;
            claim_tgt      <= do_claim ? TGT_W'(offset) : '0;
            claim_id       <= do_claim ? sel_id : '0;
            complete_valid <= do_complete;
            complete_tgt   <= do_complete ? TGT_W'(offset) : '0;
            complete_id    <= do_complete ? wdata[ID_W-1:0] : '0;
        end
    end

    // R6: a claim only follows a read request
    assert_claim_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |-> $past(rd_en));

    // R7: a completion only follows a write and names a real source
    assert_complete_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        complete_valid |-> ($past(wr_en) && complete_id != '0 && 32'(complete_id) < 32'(SRC_COUNT)));

    // R10: claim and completion never coincide
    assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(claim_valid && complete_valid));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int SRC_COUNT  = 40,
    parameter int TGT_COUNT  = 2,
    parameter int HART_COUNT = 2,
    parameter int PRIO_MAX   = 7,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    localparam int PRIO_W    = $clog2(PRIO_MAX + 1),
    localparam int ID_W      = $clog2(SRC_COUNT),
    localparam int TGT_W     = (TGT_COUNT > 1) ? $clog2(TGT_COUNT) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [DATA_W-1:0]              req_wdata,
    output logic                           rsp_valid,
    output logic [DATA_W-1:0]              rsp_rdata,
    input  logic [SRC_COUNT-1:0]           src_pending,
    input  logic [TGT_COUNT*ID_W-1:0]      tgt_win_id,
    output logic [SRC_COUNT*PRIO_W-1:0]    cfg_prio,
    output logic [TGT_COUNT*SRC_COUNT-1:0] cfg_enable,
    output logic [TGT_COUNT*PRIO_W-1:0]    cfg_thresh,
    output logic [HART_COUNT-1:0]          soft_irq,
    output logic                           claim_valid,
    output logic [TGT_W-1:0]               claim_tgt,
    output logic [ID_W-1:0]                claim_id,
    output logic                           complete_valid,
    output logic [TGT_W-1:0]               complete_tgt,
    output logic [ID_W-1:0]                complete_id
);
    localparam int WORDS = (SRC_COUNT + DATA_W - 1) / DATA_W;

    irqc_region_e      region;
    logic [ADDR_W-1:0] offset;
    logic              rd_en;
    logic              wr_en;
    logic [DATA_W-1:0] cfg_rdata;
    logic [DATA_W-1:0] cc_rdata;
    logic [DATA_W-1:0] pend_rdata;
    logic [DATA_W-1:0] rd_next;

    assign rd_en = req_valid && !req_write;
    assign wr_en = req_valid && req_write;

    irqc_addr_dec #(
        .SRC_COUNT (SRC_COUNT),
        .TGT_COUNT (TGT_COUNT),
        .HART_COUNT(HART_COUNT),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr  (req_addr),
        .region(region),
        .offset(offset)
    );

    irqc_cfg_store #(
        .SRC_COUNT (SRC_COUNT),
        .TGT_COUNT (TGT_COUNT),
        .HART_COUNT(HART_COUNT),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .PRIO_W    (PRIO_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .region   (region),
        .offset   (offset),
        .wdata    (req_wdata),
        .prio_q   (cfg_prio),
        .ie_q     (cfg_enable),
        .thr_q    (cfg_thresh),
        .swi_q    (soft_irq),
        .cfg_rdata(cfg_rdata)
    );

    irqc_cc_port #(
        .SRC_COUNT(SRC_COUNT),
        .TGT_COUNT(TGT_COUNT),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .ID_W     (ID_W),
        .TGT_W    (TGT_W)
    ) u_cc (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_en         (rd_en),
        .wr_en         (wr_en),
        .region        (region),
        .offset        (offset),
        .wdata         (req_wdata),
        .win_id        (tgt_win_id),
        .cc_rdata      (cc_rdata),
        .claim_valid   (claim_valid),
        .claim_tgt     (claim_tgt),
        .claim_id      (claim_id),
        .complete_valid(complete_valid),
        .complete_tgt  (complete_tgt),
        .complete_id   (complete_id)
    );

    // Pending view: read-only window onto the gateway outputs
    always_comb begin
        pend_rdata = '0;
        for (int w = 0; w < WORDS; w++)
            if (offset == ADDR_W'(w))
                for (int b = 0; b < DATA_W; b++)
                    if (w * DATA_W + b < SRC_COUNT)
                        pend_rdata[b] = src_pending[w*DATA_W + b];
    end

    always_comb begin
        unique case (region)
            RG_PEND: rd_next = pend_rdata;
            RG_CC:   rd_next = cc_rdata;
            default: rd_next = cfg_rdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? rd_next : '0;
        end
    end

    // R9: read data appears exactly one cycle after a read request
    assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_en));

    // R9: an unmapped read returns zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && region == RG_NONE) |=> (rsp_rdata == '0));

    // R6: a claim comes with a read response carrying the same ID
    assert_claim_matches_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |-> (rsp_valid && rsp_rdata == DATA_W'(claim_id)));

endmodule

// File: tb/irqc_regs_tb.sv
`timescale 1ns/1ps
module irqc_regs_tb;
    localparam int N  = 40;
    localparam int T  = 2;
    localparam int H  = 2;
    localparam int PW = 3;
    localparam int IW = 6;
    localparam int W  = 2;
    localparam int PEND_B = N;
    localparam int IE_B   = N + W;
    localparam int THR_B  = IE_B + T * W;
    localparam int CC_B   = THR_B + T;
    localparam int SWI_B  = CC_B + T;
    localparam int END_B  = SWI_B + H;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [N-1:0]  src_pending = '0;
    logic [T*IW-1:0] tgt_win_id = '0;
    logic [N*PW-1:0] cfg_prio;
    logic [T*N-1:0]  cfg_enable;
    logic [T*PW-1:0] cfg_thresh;
    logic [H-1:0]    soft_irq;
    logic            claim_valid;
    logic [0:0]      claim_tgt;
    logic [IW-1:0]   claim_id;
    logic            complete_valid;
    logic [0:0]      complete_tgt;
    logic [IW-1:0]   complete_id;

    always #4 clk = ~clk;

    irqc_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .src_pending(src_pending), .tgt_win_id(tgt_win_id),
        .cfg_prio(cfg_prio), .cfg_enable(cfg_enable), .cfg_thresh(cfg_thresh), .soft_irq(soft_irq),
        .claim_valid(claim_valid), .claim_tgt(claim_tgt), .claim_id(claim_id),
        .complete_valid(complete_valid), .complete_tgt(complete_tgt), .complete_id(complete_id)
    );

    int vecs = 0;
    int errs = 0;

    // reference model
    logic [PW-1:0] m_prio [N];
    logic [T*N-1:0] m_ie;
    logic [PW-1:0] m_thr [T];
    logic [H-1:0]  m_swi;

    // captured outputs one edge after a request
    logic        c_rv, c_cv, c_kv;
    logic [31:0] c_rd;
    logic [0:0]  c_ct, c_kt;
    logic [IW-1:0] c_ci, c_ki;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input int a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 8'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        c_rv = rsp_valid; c_rd = rsp_rdata;
        c_cv = claim_valid; c_ct = claim_tgt; c_ci = claim_id;
        c_kv = complete_valid; c_kt = complete_tgt; c_ki = complete_id;
    endtask

    function automatic logic [N*PW-1:0] exp_prio();
        logic [N*PW-1:0] v;
        for (int i = 0; i < N; i++) v[i*PW +: PW] = m_prio[i];
        return v;
    endfunction

    function automatic logic [T*PW-1:0] exp_thr();
        logic [T*PW-1:0] v;
        for (int t = 0; t < T; t++) v[t*PW +: PW] = m_thr[t];
        return v;
    endfunction

    function automatic logic [31:0] exp_ie_word(input int t, input int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 32; b++) if (w * 32 + b < N) v[b] = m_ie[t*N + w*32 + b];
        return v;
    endfunction

    function automatic logic [31:0] exp_pend_word(input int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 32; b++) if (w * 32 + b < N) v[b] = src_pending[w*32 + b];
        return v;
    endfunction

    task automatic check_cfg(input string req);
        check(req, 128'(cfg_prio), 128'(exp_prio()));
        check(req, 128'(cfg_enable), 128'(m_ie));
        check(req, 128'(cfg_thresh), 128'(exp_thr()));
        check(req, 128'(soft_irq), 128'(m_swi));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_prio[i] = '0;
        for (int t = 0; t < T; t++) m_thr[t] = '0;
        m_ie = '0; m_swi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state on the ports and across the whole map
        check_cfg("R1 reset config");
        check("R1 reset pulses", {claim_valid, complete_valid, rsp_valid}, 0);
        for (int a = 0; a < END_B; a++) begin
            bus_op(1'b0, a, 32'h0);
            check("R1 reset read", c_rd, 0);
            check("R1 reset claim", c_cv, 0);
        end

        // R2: priority sweep, upper bits dropped
        for (int i = 0; i < N; i++) begin
            logic [31:0] d = 32'hABCD_0000 | 32'((i * 37 + 5) & 32'hFF);
            bus_op(1'b1, i, d);
            m_prio[i] = d[PW-1:0];
            check("R2 prio output", 128'(cfg_prio[i*PW +: PW]), 128'(m_prio[i]));
            check("R9 no rsp on write", c_rv, 0);
        end
        for (int i = 0; i < N; i++) begin
            bus_op(1'b0, i, 32'h0);
            check("R2 prio readback", c_rd, 32'(m_prio[i]));
        end

        // R3: enable words with packed offset formula
        for (int t = 0; t < T; t++)
            for (int w = 0; w < W; w++) begin
                logic [31:0] d = 32'h9E37_79B9 * 32'(t * 2 + w + 1);
                bus_op(1'b1, IE_B + W * t + w, d);
                for (int b = 0; b < 32; b++) if (w * 32 + b < N) m_ie[t*N + w*32 + b] = d[b];
                check("R3 enable vector", 128'(cfg_enable), 128'(m_ie));
            end
        for (int t = 0; t < T; t++)
            for (int w = 0; w < W; w++) begin
                bus_op(1'b0, IE_B + W * t + w, 32'h0);
                check("R3 enable readback", c_rd, exp_ie_word(t, w));
            end
        // single-source enable set via formula
        bus_op(1'b1, IE_B + W * 1 + (37 >> 5), 32'(1) << (37 % 32));
        for (int b = 0; b < 32; b++) if (32 + b < N) m_ie[N + 32 + b] = (b == 5);
        check("R3 single enable", 128'(cfg_enable[N + 37]), 1);
        check("R3 enable vector", 128'(cfg_enable), 128'(m_ie));

        // R4: thresholds
        for (int t = 0; t < T; t++) begin
            logic [31:0] d = 32'hFFFF_FFF0 | 32'(t + 5);
            bus_op(1'b1, THR_B + t, d);
            m_thr[t] = d[PW-1:0];
            check("R4 threshold output", 128'(cfg_thresh), 128'(exp_thr()));
            bus_op(1'b0, THR_B + t, 0);
            check("R4 threshold readback", c_rd, 32'(m_thr[t]));
        end

        // R5: pending view under several patterns, writes inert
        for (int p = 0; p < 6; p++) begin
            case (p)
                0: src_pending = '0;
                1: src_pending = '1;
                2: src_pending = 40'hA5_5A0F_F00F;
                3: src_pending = 40'h80_0000_0001;
                4: src_pending = 40'h01_0000_0000;
                default: src_pending = 40'h7F_FFFF_FFFE;
            endcase
            for (int w = 0; w < W; w++) begin
                bus_op(1'b0, PEND_B + w, 0);
                check("R5 pending read", c_rd, exp_pend_word(w));
                bus_op(1'b1, PEND_B + w, 32'hFFFF_FFFF);
                check_cfg("R5 pending write inert");
                bus_op(1'b0, PEND_B + w, 0);
                check("R5 pending after write", c_rd, exp_pend_word(w));
            end
        end

        // R6: claims
        for (int t = 0; t < T; t++)
            for (int k = 0; k < 5; k++) begin
                int id;
                case (k)
                    0: id = 0;
                    1: id = 1;
                    2: id = 5 + t;
                    3: id = 38;
                    default: id = N - 1;
                endcase
                tgt_win_id = '0;
                tgt_win_id[t*IW +: IW] = IW'(id);
                tgt_win_id[(1-t)*IW +: IW] = IW'(17);
                bus_op(1'b0, CC_B + t, 0);
                check("R6 cc read data", c_rd, 32'(id));
                check("R6 rsp valid", c_rv, 1);
                check("R6 claim valid", c_cv, (id != 0));
                check("R6 claim tgt", c_ct, (id != 0) ? t : 0);
                check("R6 claim id", c_ci, (id != 0) ? id : 0);
                check("R6 no complete", c_kv, 0);
                @(negedge clk);
                check("R6 claim one cycle", claim_valid, 0);
            end

        // R7: completion sweep
        for (int t = 0; t < T; t++)
            for (int v = 0; v < 65; v++) begin
                logic [31:0] d = (v == 64) ? 32'h105 : 32'(v);
                logic ok = (d != 0) && (d < N);
                bus_op(1'b1, CC_B + t, d);
                check("R7 complete valid", c_kv, ok);
                check("R7 complete tgt", c_kt, ok ? t : 0);
                check("R7 complete id", c_ki, ok ? d[IW-1:0] : 0);
                check("R7 no claim", c_cv, 0);
            end
        check_cfg("R7 cc write inert");

        // R8: software interrupt bits
        for (int h = 0; h < H; h++) begin
            bus_op(1'b1, SWI_B + h, 32'hFFFF_FFFF);
            m_swi[h] = 1'b1;
            check("R8 soft irq set", soft_irq, m_swi);
            bus_op(1'b0, SWI_B + h, 0);
            check("R8 soft irq read", c_rd, 1);
        end
        bus_op(1'b1, SWI_B, 32'hFFFF_FFFE);
        m_swi[0] = 1'b0;
        check("R8 soft irq clear", soft_irq, m_swi);

        // R9 and R10: unmapped space above the map end
        for (int a = END_B; a < 256; a++) begin
            bus_op(1'b1, a, 32'hFFFF_FFFF);
            bus_op(1'b0, a, 0);
            check("R9 unmapped read", c_rd, 0);
            check("R9 unmapped rsp", c_rv, 1);
        end
        check_cfg("R10 map end, unmapped writes inert");

        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule